// File: doc/BRIEF.md
# Banked Integer Register File

This block is the architectural register store of a 32-bit CISC integer core. It keeps eight data registers, seven general address registers, a program counter and a small mode register holding the supervisor bit and a 3-bit interrupt mask. Address register 7 is not a single register. It is a pair of stack pointers, one for user mode and one for supervisor mode. The current supervisor bit decides which of the two any access to index 7 reaches.

The execute stage reads one operand through a combinational read port. That port returns a byte, word or long view of the selected register. Results go back through a synchronous write port whose size code controls merging: narrower writes replace only the low bits and keep the rest of the register. A byte-sized write aimed at an address register is refused, and a one-cycle illegal-write flag reports it.

Exception and stack logic has its own port to either stack pointer, independent of the current mode. The register file accepts a read and a write in every cycle and never stalls, so the ports are plain enables with no valid/ready handshake and no back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: After reset the following read as zero: every data register, every address register, both stack pointers and the program counter. `sup_mode` reads 1, `int_mask` reads 7 and `illegal_wr` reads 0.
- R2: The write port and the read port each treat address index 7 as the supervisor stack pointer when `sup_mode` is 1, and as the user stack pointer when it is 0. For a write, this uses the mode value held before the clock edge.
- R3: A byte write (size code 0) to a data register (`wr_type` 0) replaces bits 7:0 and leaves bits 31:8 unchanged.
- R4: A word write (size code 1) to a data or address register replaces bits 15:0 and leaves bits 31:16 unchanged.
- R5: A byte write to an address register (`wr_type` 1, size code 0) changes no register. `illegal_wr` is 1 in the cycle after such a write and 0 after any other cycle.
- R6: A read with size code 0 returns the low 8 bits of the register, zero-extended. Size code 1 returns the low 16 bits, zero-extended. Size codes 2 and 3 return all 32 bits.
- R7: A long write (size code 2 or 3) replaces the whole register at the next rising edge. A read of the same register in the write's own cycle returns the old contents.
- R8: The stack-pointer port reads the user stack pointer when `sp_sel` is 0 and the supervisor stack pointer when it is 1, whatever the mode. A write through this port replaces all 32 bits. When it targets the same pointer as the write port in the same cycle, the stack-pointer port wins.
- R9: When `pc_we` is 1, the program counter takes `pc_wdata` at the next edge. Otherwise it holds its value.
- R10: When `mode_we` is 1, the supervisor bit and interrupt mask take `mode_sup_in` and `mode_mask_in` at the next edge. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_type | input | 1 | Read register class: 0 data, 1 address |
| rd_idx | input | 3 | Read register index |
| rd_size | input | 2 | Read view: 0 byte, 1 word, 2/3 long |
| rd_data | output | 32 | Zero-extended read view |
| wr_en | input | 1 | Write enable |
| wr_type | input | 1 | Write register class: 0 data, 1 address |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size: 0 byte, 1 word, 2/3 long |
| wr_data | input | 32 | Write value, low bits used for narrow sizes |
| illegal_wr | output | 1 | One-cycle flag for a refused byte write to an address register |
| sp_sel | input | 1 | Stack-pointer port select: 0 user, 1 supervisor |
| sp_we | input | 1 | Stack-pointer port write enable |
| sp_wdata | input | 32 | Stack-pointer port write value |
| sp_rdata | output | 32 | Selected stack pointer |
| pc_we | input | 1 | Program counter load enable |
| pc_wdata | input | 32 | Program counter load value |
| pc_q | output | 32 | Program counter |
| mode_we | input | 1 | Mode register load enable |
| mode_sup_in | input | 1 | New supervisor bit |
| mode_mask_in | input | 3 | New interrupt mask |
| sup_mode | output | 1 | Current supervisor bit |
| int_mask | output | 3 | Current interrupt mask |

## Verification
The bench starts with directed sequences. One writes a long pattern and then narrow patterns over it to each class of register, which separates a correct merge from one that clears or overwrites the upper bits. Another writes index 7 in both modes and then reads it back through the stack-pointer port, which catches a swapped or missing bank select. Next come byte writes to address registers, including index 7, and same-cycle collisions of the write port with the stack-pointer port; these expose a refused write that still lands and a wrong priority. A long stretch of mixed random traffic then toggles the mode often, which finds read-during-write ordering errors and errors that only appear when the mode changes between accesses.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } size_e;

  localparam logic RT_DATA = 1'b0;
  localparam logic RT_ADDR = 1'b1;
endpackage

// File: rtl/rf_merge.sv
module rf_merge
  import banked_rf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] old_v,
  input  logic [W-1:0] new_v,
  input  size_e        size_i,
  output logic [W-1:0] merged
);
  always_comb begin
    case (size_i)
      SZ_BYTE: merged = {old_v[W-1:8], new_v[7:0]};
      SZ_WORD: merged = {old_v[W-1:16], new_v[15:0]};
      default: merged = new_v;
    endcase
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import banked_rf_pkg::*;
#(
  parameter int W    = 32,
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDXW-1:0]     idx,
  input  size_e               size_i,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] nxt;
    rf_merge #(.W(W)) u_merge (
      .old_v (q[i]),
      .new_v (wdata),
      .size_i(size_i),
      .merged(nxt)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (we && idx == IDXW'(i)) begin
        q[i] <= nxt;
      end
    end
  end
endmodule

// File: rtl/rf_stack_pair.sv
module rf_stack_pair
  import banked_rf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         main_we,
  input  logic         sup,
  input  size_e        size_i,
  input  logic [W-1:0] wdata,
  input  logic         dir_we,
  input  logic         dir_sel,
  input  logic [W-1:0] dir_wdata,
  output logic [W-1:0] usp_q,
  output logic [W-1:0] ssp_q
);
  localparam int NSP = 2;
  logic [NSP-1:0][W-1:0] sp_q;

  for (genvar k = 0; k < NSP; k++) begin : g_sp
    logic [W-1:0] nxt;
    rf_merge #(.W(W)) u_merge (
      .old_v (sp_q[k]),
      .new_v (wdata),
      .size_i(size_i),
      .merged(nxt)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp_q[k] <= '0;
      end else if (dir_we && dir_sel == 1'(k)) begin
        sp_q[k] <= dir_wdata;
      end else if (main_we && sup == 1'(k)) begin
        sp_q[k] <= nxt;
      end
    end
  end

  assign usp_q = sp_q[0];
  assign ssp_q = sp_q[1];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int W     = 32,
  parameter int NREG  = 8,
  parameter int MASKW = 3,
  localparam int IDXW = $clog2(NREG),
  localparam int NGEN = NREG - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_type,
  input  logic [IDXW-1:0]  rd_idx,
  input  logic [1:0]       rd_size,
  output logic [W-1:0]     rd_data,
  input  logic             wr_en,
  input  logic             wr_type,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [1:0]       wr_size,
  input  logic [W-1:0]     wr_data,
  output logic             illegal_wr,
  input  logic             sp_sel,
  input  logic             sp_we,
  input  logic [W-1:0]     sp_wdata,
  output logic [W-1:0]     sp_rdata,
  input  logic             pc_we,
  input  logic [W-1:0]     pc_wdata,
  output logic [W-1:0]     pc_q,
  input  logic             mode_we,
  input  logic             mode_sup_in,
  input  logic [MASKW-1:0] mode_mask_in,
  output logic             sup_mode,
  output logic [MASKW-1:0] int_mask
);
  localparam logic [IDXW-1:0] SP_IDX = IDXW'(NREG - 1);

  size_e wsz;
  size_e rsz;
  assign wsz = size_e'(wr_size);
  assign rsz = size_e'(rd_size);

  logic [NREG-1:0][W-1:0] d_q;
  logic [NGEN-1:0][W-1:0] a_q;
  logic [W-1:0]           usp_q;
  logic [W-1:0]           ssp_q;
  logic                   sup_q;
  logic [MASKW-1:0]       mask_q;

  logic d_we;
  logic a_any_we;
  logic a_gen_we;
  logic a_sp_we;
  logic byte_to_addr;

  assign byte_to_addr = wr_en && (wr_type == RT_ADDR) && (wsz == SZ_BYTE);
  assign d_we         = wr_en && (wr_type == RT_DATA);
  assign a_any_we     = wr_en && (wr_type == RT_ADDR) && (wsz != SZ_BYTE);
  assign a_gen_we     = a_any_we && (wr_idx != SP_IDX);
  assign a_sp_we      = a_any_we && (wr_idx == SP_IDX);

  rf_bank #(.W(W), .N(NREG), .IDXW(IDXW)) u_dbank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (d_we),
    .idx   (wr_idx),
    .size_i(wsz),
    .wdata (wr_data),
    .q     (d_q)
  );

  rf_bank #(.W(W), .N(NGEN), .IDXW(IDXW)) u_abank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (a_gen_we),
    .idx   (wr_idx),
    .size_i(wsz),
    .wdata (wr_data),
    .q     (a_q)
  );

  rf_stack_pair #(.W(W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .main_we  (a_sp_we),
    .sup      (sup_q),
    .size_i   (wsz),
    .wdata    (wr_data),
    .dir_we   (sp_we),
    .dir_sel  (sp_sel),
    .dir_wdata(sp_wdata),
    .usp_q    (usp_q),
    .ssp_q    (ssp_q)
  );

  // Mode, program counter and illegal-write flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q      <= 1'b1;
      mask_q     <= '1;
      pc_q       <= '0;
      illegal_wr <= 1'b0;
    end else begin
      illegal_wr <= byte_to_addr;
      if (mode_we) begin
        sup_q  <= mode_sup_in;
        mask_q <= mode_mask_in;
      end
      if (pc_we) begin
        pc_q <= pc_wdata;
      end
    end
  end

  // Read path: select the register, then cut the view
  logic [W-1:0] rd_long;
  always_comb begin
    if (rd_type == RT_DATA) begin
      rd_long = d_q[rd_idx];
    end else if (rd_idx == SP_IDX) begin
      rd_long = sup_q ? ssp_q : usp_q;
    end else begin
      rd_long = a_q[rd_idx];
    end
  end

  always_comb begin
    case (rsz)
      SZ_BYTE: rd_data = {{(W-8){1'b0}}, rd_long[7:0]};
      SZ_WORD: rd_data = {{(W-16){1'b0}}, rd_long[15:0]};
      default: rd_data = rd_long;
    endcase
  end

  assign sp_rdata = sp_sel ? ssp_q : usp_q;
  assign sup_mode = sup_q;
  assign int_mask = mask_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int IDXW = 3,
  parameter int NGEN = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   wr_type,
  input logic [IDXW-1:0]        wr_idx,
  input logic [1:0]             wr_size,
  input logic [W-1:0]           wr_data,
  input logic                   illegal_wr,
  input logic                   sp_we,
  input logic                   sp_sel,
  input logic [W-1:0]           sp_wdata,
  input logic                   sup_mode,
  input logic [NREG-1:0][W-1:0] d_q,
  input logic [NGEN-1:0][W-1:0] a_q,
  input logic [W-1:0]           usp_q,
  input logic [W-1:0]           ssp_q
);
  localparam logic [IDXW-1:0] TOP = IDXW'(NREG - 1);

  AST_ILLEGAL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_type && wr_size == 2'd0) |=> illegal_wr); // R5
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_type && wr_size == 2'd0) |=> !illegal_wr); // R5
  AST_ADDR_BYTE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_type && wr_size == 2'd0 && !sp_we) |=>
      ($stable(a_q) && $stable(usp_q) && $stable(ssp_q))); // R5
  AST_BYTE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_type && wr_size == 2'd0) |=>
      d_q[$past(wr_idx)][W-1:8] == $past(d_q[wr_idx][W-1:8])); // R3
  AST_WORD_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_type && wr_size == 2'd1) |=>
      d_q[$past(wr_idx)][W-1:16] == $past(d_q[wr_idx][W-1:16])); // R4
  AST_A7_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_type && wr_idx == TOP && wr_size == 2'd2 && sup_mode && !sp_we) |=>
      (ssp_q == $past(wr_data) && $stable(usp_q))); // R2
  AST_A7_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_type && wr_idx == TOP && wr_size == 2'd2 && !sup_mode && !sp_we) |=>
      (usp_q == $past(wr_data) && $stable(ssp_q))); // R2
  AST_SP_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_sel) |=> ssp_q == $past(sp_wdata)); // R8
endmodule

bind banked_regfile banked_regfile_chk #(
  .W(W), .NREG(NREG), .IDXW(IDXW), .NGEN(NGEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_type   (wr_type),
  .wr_idx    (wr_idx),
  .wr_size   (wr_size),
  .wr_data   (wr_data),
  .illegal_wr(illegal_wr),
  .sp_we     (sp_we),
  .sp_sel    (sp_sel),
  .sp_wdata  (sp_wdata),
  .sup_mode  (sup_mode),
  .d_q       (d_q),
  .a_q       (a_q),
  .usp_q     (usp_q),
  .ssp_q     (ssp_q)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_type = 0;
  logic [2:0]  rd_idx = 0;
  logic [1:0]  rd_size = 0;
  logic [31:0] rd_data;
  logic        wr_en = 0;
  logic        wr_type = 0;
  logic [2:0]  wr_idx = 0;
  logic [1:0]  wr_size = 0;
  logic [31:0] wr_data = 0;
  logic        illegal_wr;
  logic        sp_sel = 0;
  logic        sp_we = 0;
  logic [31:0] sp_wdata = 0;
  logic [31:0] sp_rdata;
  logic        pc_we = 0;
  logic [31:0] pc_wdata = 0;
  logic [31:0] pc_q;
  logic        mode_we = 0;
  logic        mode_sup_in = 0;
  logic [2:0]  mode_mask_in = 0;
  logic        sup_mode;
  logic [2:0]  int_mask;

  always #4 clk = ~clk;

  banked_regfile dut (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_d [8];
  logic [31:0] m_a [7];
  logic [31:0] m_usp, m_ssp, m_pc;
  logic        m_sup, m_ill;
  logic [2:0]  m_mask;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [1:0] s);
    case (s)
      2'd0:    return (o & 32'hFFFF_FF00) | (n & 32'h0000_00FF);
      2'd1:    return (o & 32'hFFFF_0000) | (n & 32'h0000_FFFF);
      default: return n;
    endcase
  endfunction

  function automatic logic [31:0] m_get(input logic t, input logic [2:0] i);
    if (!t) return m_d[i];
    if (i == 3'd7) return m_sup ? m_ssp : m_usp;
    return m_a[i];
  endfunction

  function automatic logic [31:0] m_read(input logic t, input logic [2:0] i,
                                         input logic [1:0] s);
    logic [31:0] v = m_get(t, i);
    case (s)
      2'd0:    return v & 32'h0000_00FF;
      2'd1:    return v & 32'h0000_FFFF;
      default: return v;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_d[i] = 0;
    for (int i = 0; i < 7; i++) m_a[i] = 0;
    m_usp = 0; m_ssp = 0; m_pc = 0; m_sup = 1; m_mask = 3'd7; m_ill = 0;
  endtask

  task automatic m_update();
    logic [31:0] nd [8];
    logic [31:0] na [7];
    logic [31:0] nusp, nssp;
    for (int i = 0; i < 8; i++) nd[i] = m_d[i];
    for (int i = 0; i < 7; i++) na[i] = m_a[i];
    nusp = m_usp; nssp = m_ssp;
    m_ill = wr_en && wr_type && wr_size == 2'd0;
    if (wr_en && !wr_type) nd[wr_idx] = merge(m_d[wr_idx], wr_data, wr_size);
    else if (wr_en && wr_type && wr_size != 2'd0) begin
      if (wr_idx != 3'd7) na[wr_idx] = merge(m_a[wr_idx], wr_data, wr_size);
      else if (m_sup) nssp = merge(m_ssp, wr_data, wr_size);
      else nusp = merge(m_usp, wr_data, wr_size);
    end
    if (sp_we) begin
      if (sp_sel) nssp = sp_wdata; else nusp = sp_wdata;
    end
    if (pc_we) m_pc = pc_wdata;
    if (mode_we) begin m_sup = mode_sup_in; m_mask = mode_mask_in; end
    for (int i = 0; i < 8; i++) m_d[i] = nd[i];
    for (int i = 0; i < 7; i++) m_a[i] = na[i];
    m_usp = nusp; m_ssp = nssp;
  endtask

  function automatic string rd_tag();
    if (rd_size == 2'd0 || rd_size == 2'd1) return "R6";
    if (rd_type && rd_idx == 3'd7) return "R2";
    return "R7";
  endfunction

  // Compare every output with the model, then clock once
  task automatic step();
    #1;
    chk(rd_data === m_read(rd_type, rd_idx, rd_size), rd_tag(), "rd_data",
        rd_data, m_read(rd_type, rd_idx, rd_size));
    chk(illegal_wr === m_ill, "R5", "illegal_wr", 32'(illegal_wr), 32'(m_ill));
    chk(sp_rdata === (sp_sel ? m_ssp : m_usp), "R8", "sp_rdata", sp_rdata,
        sp_sel ? m_ssp : m_usp);
    chk(pc_q === m_pc, "R9", "pc_q", pc_q, m_pc);
    chk(sup_mode === m_sup && int_mask === m_mask, "R10", "mode",
        {28'd0, sup_mode, int_mask}, {28'd0, m_sup, m_mask});
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; sp_we = 0; pc_we = 0; mode_we = 0;
  endtask

  task automatic wr(input logic t, input logic [2:0] i, input logic [1:0] s,
                    input logic [31:0] v);
    idle();
    wr_en = 1; wr_type = t; wr_idx = i; wr_size = s; wr_data = v;
    rd_type = t; rd_idx = i; rd_size = 2'd2;
    step();
    idle();
  endtask

  task automatic rd(input logic t, input logic [2:0] i, input logic [1:0] s);
    idle();
    rd_type = t; rd_idx = i; rd_size = s;
    step();
  endtask

  task automatic set_mode(input logic s);
    idle();
    mode_we = 1; mode_sup_in = s; mode_mask_in = 3'd7;
    step();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset contents
    for (int i = 0; i < 8; i++) begin
      rd(0, 3'(i), 2'd2);
      chk(rd_data === 32'd0, "R1", "data reg after reset", rd_data, 0);
      rd(1, 3'(i), 2'd2);
      chk(rd_data === 32'd0, "R1", "addr reg after reset", rd_data, 0);
    end
    chk(sup_mode === 1'b1 && int_mask === 3'd7 && illegal_wr === 1'b0, "R1",
        "mode after reset", {28'd0, sup_mode, int_mask}, 32'hF);

    // R3 / R4 / R7: merges into data and address registers
    wr(0, 3'd2, 2'd2, 32'hDEAD_BEEF);
    wr(0, 3'd2, 2'd0, 32'h1234_5678);
    rd(0, 3'd2, 2'd2);
    chk(rd_data === 32'hDEAD_BE78, "R3", "byte merge", rd_data, 32'hDEAD_BE78);
    wr(0, 3'd2, 2'd1, 32'hAAAA_5555);
    rd(0, 3'd2, 2'd2);
    chk(rd_data === 32'hDEAD_5555, "R4", "word merge data", rd_data, 32'hDEAD_5555);
    wr(1, 3'd3, 2'd3, 32'hCAFE_F00D);
    wr(1, 3'd3, 2'd1, 32'h0000_1111);
    rd(1, 3'd3, 2'd2);
    chk(rd_data === 32'hCAFE_1111, "R4", "word merge addr", rd_data, 32'hCAFE_1111);

    // R5: byte write to address register dropped, flag pulses
    wr(1, 3'd3, 2'd0, 32'h0000_0099);
    chk(illegal_wr === 1'b1, "R5", "flag raised", 32'(illegal_wr), 1);
    rd(1, 3'd3, 2'd2);
    chk(rd_data === 32'hCAFE_1111, "R5", "addr unchanged", rd_data, 32'hCAFE_1111);
    chk(illegal_wr === 1'b0, "R5", "flag one cycle", 32'(illegal_wr), 0);

    // R2: index 7 banking in both modes
    wr(1, 3'd7, 2'd2, 32'h0000_8000);
    set_mode(0);
    wr(1, 3'd7, 2'd2, 32'h0000_4000);
    wr(1, 3'd7, 2'd0, 32'h0000_00FF);
    rd(1, 3'd7, 2'd2);
    chk(rd_data === 32'h0000_4000, "R2", "user A7 read", rd_data, 32'h0000_4000);
    idle(); sp_sel = 1; rd(1, 3'd7, 2'd2);
    chk(sp_rdata === 32'h0000_8000, "R8", "ssp in user mode", sp_rdata, 32'h0000_8000);
    set_mode(1);
    rd(1, 3'd7, 2'd1);
    chk(rd_data === 32'h0000_8000, "R2", "sup A7 word read", rd_data, 32'h0000_8000);

    // R8: collision, stack port wins
    idle();
    wr_en = 1; wr_type = 1; wr_idx = 3'd7; wr_size = 2'd2; wr_data = 32'h1111_1111;
    sp_we = 1; sp_sel = 1; sp_wdata = 32'h2222_2222;
    step();
    idle(); rd(1, 3'd7, 2'd2);
    chk(rd_data === 32'h2222_2222, "R8", "stack port priority", rd_data, 32'h2222_2222);

    // R9: PC load
    idle(); pc_we = 1; pc_wdata = 32'h0000_1000; step(); idle(); step();
    chk(pc_q === 32'h0000_1000, "R9", "pc load", pc_q, 32'h0000_1000);

    // Mixed traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      wr_en        = ($urandom % 4) != 0;
      wr_type      = 1'($urandom);
      wr_idx       = 3'($urandom);
      wr_size      = 2'($urandom);
      wr_data      = $urandom;
      rd_type      = 1'($urandom);
      rd_idx       = ($urandom % 3 == 0) ? wr_idx : 3'($urandom);
      rd_size      = 2'($urandom);
      sp_sel       = 1'($urandom);
      sp_we        = ($urandom % 6) == 0;
      sp_wdata     = $urandom;
      pc_we        = ($urandom % 5) == 0;
      pc_wdata     = $urandom;
      mode_we      = ($urandom % 7) == 0;
      mode_sup_in  = 1'($urandom);
      mode_mask_in = 3'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule